// File: doc/BRIEF.md
# Microwire-Style Serial EEPROM Command Controller

This block sits between a host register port and a small serial EEPROM that uses a chip-select, serial clock, data-in and data-out wire set. The host writes a one-byte command into a command register. Bits 7:6 of that byte are the operation code and bits 5:0 are the word address. The controller then runs the whole serial exchange on its own and raises a busy flag until the exchange is finished. A separate data register holds the 16-bit word for a write, and it receives the word returned by a read.

Each serial frame starts with chip select high. The controller then sends a start bit of 1, the 2-bit operation code and the 6-bit address, most significant bit first. The serial clock is the system clock divided by 2*CLK_DIV. Op code 2 reads a word. Op code 1 writes the data register contents. Op code 3 erases a word. Op code 0 carries special commands, and the value 0x30 among them unlocks programming.

To update a word, software issues these commands in order: unlock, erase, load the data register, unlock again, then write. After an erase or a write, the controller waits for the device to signal that its internal programming cycle has ended. Software keeps the stored checksum up to date itself.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: After reset, chip select, serial clock and data-in are low, and both registers read 0.
- R2: The command register is at offset CMD_OFS (0x0A) and the data register at DATA_OFS (0x0C). A data write made while idle reads back unchanged. Every other offset reads 0.
- R3: From the clock after an accepted command write until the operation ends, the command register reads busy in bit 15. Bits 7:0 always show the last accepted command, and bits 14:8 read 0.
- R4: Every frame holds chip select high and sends 1, then command bits 7 through 0 in that order. Data-in changes only while the serial clock is low. The serial clock period is 2*CLK_DIV system clocks. Serial clock and chip select stay low while idle.
- R5: A read (op code 2) clocks one dummy bit and then 16 data bits, MSB first, sampled while the serial clock is high. The word appears in the data register in the cycle busy clears, for a total of 25 serial clocks.
- R6: A command with op code 0 (such as 0x30, unlock) sends only its 9-bit frame and then finishes.
- R7: A write (op code 1) follows its frame with the 16 data-register bits, MSB first. After the frame of an erase (op code 3) or a write, chip select goes low for GAP_TICKS half-periods and then high again. Busy then holds until data-out is sampled high.
- R8: A write to either register while busy has no effect.
- R9: An erase or write issued without a prior unlock still runs its full frame. When the device reports ready at once, busy clears without a programming wait and the stored word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | REG_AW | Register offset |
| host_we | input | 1 | Register write strobe |
| host_wdata | input | WORD_BITS | Register write data |
| host_rdata | output | WORD_BITS | Register read data (combinational from host_addr) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The bench builds the block with a 6-bit address and 16-bit words, so the table can reach both end addresses, 0x00 and 0x3F. It uses CLK_DIV = 3, which makes each serial half-period span three system clocks. Because of that spacing, the frame capture can time the serial clock period exactly and can show that data-in never moves while the serial clock is high. The EEPROM model in the bench takes 200 cycles to program, which is longer than any frame. A busy time that was cut short would therefore show clearly, and so would a locked device that skips the wait.

// File: rtl/uwe_pkg.sv
package uwe_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SHIFT,
    SQ_GAP,
    SQ_POLL
  } sq_state_t;

  localparam int OPC_BITS = 2;

  localparam logic [OPC_BITS-1:0] OPC_MISC  = 2'b00;
  localparam logic [OPC_BITS-1:0] OPC_WRITE = 2'b01;
  localparam logic [OPC_BITS-1:0] OPC_READ  = 2'b10;
  localparam logic [OPC_BITS-1:0] OPC_ERASE = 2'b11;

  // operation that is followed by a 16-bit data phase on the wire
  function automatic logic carries_word(input logic [OPC_BITS-1:0] opc);
    return (opc == OPC_WRITE) || (opc == OPC_READ);
  endfunction

  // operation that starts an internal program cycle in the device
  function automatic logic needs_program(input logic [OPC_BITS-1:0] opc);
    return (opc == OPC_WRITE) || (opc == OPC_ERASE);
  endfunction

endpackage

// File: rtl/uwe_divider.sv
module uwe_divider #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);

endmodule

// File: rtl/uwe_hostregs.sv
module uwe_hostregs #(
  parameter int REG_AW    = 4,
  parameter int WORD_BITS = 16,
  parameter int CMD_W     = 8,
  parameter logic [REG_AW-1:0] CMD_OFS  = 4'hA,
  parameter logic [REG_AW-1:0] DATA_OFS = 4'hC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_AW-1:0]    host_addr,
  input  logic                 host_we,
  input  logic [WORD_BITS-1:0] host_wdata,
  output logic [WORD_BITS-1:0] host_rdata,
  input  logic                 busy,
  input  logic [CMD_W-1:0]     cur_cmd,
  input  logic                 rd_done,
  input  logic [WORD_BITS-1:0] rd_word,
  output logic                 start,
  output logic                 dat_wr_ok,
  output logic [WORD_BITS-1:0] data_q
);

  localparam int PAD_W = WORD_BITS - 1 - CMD_W;

  logic [WORD_BITS-1:0] cmd_view;

  assign start     = host_we && (host_addr == CMD_OFS) && !busy;
  assign dat_wr_ok = host_we && (host_addr == DATA_OFS) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (dat_wr_ok) begin
      data_q <= host_wdata;
    end else if (rd_done) begin
      data_q <= rd_word;
    end
  end

  assign cmd_view = {busy, {PAD_W{1'b0}}, cur_cmd};

  always_comb begin
    if (host_addr == CMD_OFS) begin
      host_rdata = cmd_view;
    end else if (host_addr == DATA_OFS) begin
      host_rdata = data_q;
    end else begin
      host_rdata = '0;
    end
  end

endmodule

// File: rtl/uwe_seq.sv
module uwe_seq
  import uwe_pkg::*;
#(
  parameter int ADDR_BITS = 6,
  parameter int WORD_BITS = 16,
  parameter int GAP_TICKS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [OPC_BITS+ADDR_BITS-1:0] cmd_in,
  input  logic [WORD_BITS-1:0]          word_in,
  input  logic                          tick,
  input  logic                          ee_do,
  output logic                          busy,
  output logic                          run,
  output logic                          in_poll,
  output logic                          ee_cs,
  output logic                          ee_sk,
  output logic                          ee_di,
  output logic                          rd_done,
  output logic [WORD_BITS-1:0]          rd_word,
  output logic [OPC_BITS+ADDR_BITS-1:0] cur_cmd
);

  localparam int CMD_W    = OPC_BITS + ADDR_BITS;
  localparam int HDR_LEN  = 1 + CMD_W;
  localparam int FULL_LEN = HDR_LEN + WORD_BITS;
  localparam int IDX_W    = $clog2(FULL_LEN + 1);
  localparam int GAP_W    = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;

  // index of the last serial cycle of a frame for a given operation
  function automatic logic [IDX_W-1:0] last_idx(input logic [OPC_BITS-1:0] opc);
    return carries_word(opc) ? IDX_W'(FULL_LEN - 1) : IDX_W'(HDR_LEN - 1);
  endfunction

  // value on data-in during serial cycle i of a frame
  function automatic logic frame_bit(input logic [CMD_W-1:0]     c,
                                     input logic [WORD_BITS-1:0] w,
                                     input logic [IDX_W-1:0]     i);
    logic [HDR_LEN-1:0]   hs;
    logic [WORD_BITS-1:0] ws;
    hs = {1'b1, c} << i;
    ws = w << (i - IDX_W'(HDR_LEN));
    if (i < IDX_W'(HDR_LEN)) begin
      return hs[HDR_LEN-1];
    end
    if (c[CMD_W-1 -: OPC_BITS] == OPC_WRITE) begin
      return ws[WORD_BITS-1];
    end
    return 1'b0;
  endfunction

  sq_state_t            state;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     idx_nx;
  logic [GAP_W-1:0]     gap_cnt;
  logic [WORD_BITS-1:0] word_q;
  logic [WORD_BITS-1:0] rx_sr;
  logic [OPC_BITS-1:0]  opc;
  logic                 fall_tick;
  logic                 at_last;
  logic                 sample_now;

  assign opc        = cur_cmd[CMD_W-1 -: OPC_BITS];
  assign idx_nx     = idx + 1'b1;
  assign fall_tick  = (state == SQ_SHIFT) && tick && ee_sk;
  assign at_last    = (idx == last_idx(opc));
  assign sample_now = (opc == OPC_READ) && (idx >= IDX_W'(HDR_LEN));

  assign busy    = (state != SQ_IDLE);
  assign run     = busy;
  assign in_poll = (state == SQ_POLL);
  assign rd_done = fall_tick && at_last && (opc == OPC_READ);
  assign rd_word = {rx_sr[WORD_BITS-2:0], ee_do};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
      ee_di   <= 1'b0;
      idx     <= '0;
      gap_cnt <= '0;
      cur_cmd <= '0;
      word_q  <= '0;
      rx_sr   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start) begin
            cur_cmd <= cmd_in;
            word_q  <= word_in;
            ee_cs   <= 1'b1;
            ee_sk   <= 1'b0;
            ee_di   <= frame_bit(cmd_in, word_in, '0);
            idx     <= '0;
            state   <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: begin
          if (tick) begin
            if (!ee_sk) begin
              ee_sk <= 1'b1;
            end else begin
              ee_sk <= 1'b0;
              if (sample_now) begin
                rx_sr <= {rx_sr[WORD_BITS-2:0], ee_do};
              end
              if (at_last) begin
                ee_cs   <= 1'b0;
                ee_di   <= 1'b0;
                gap_cnt <= '0;
                state   <= needs_program(opc) ? SQ_GAP : SQ_IDLE;
              end else begin
                idx   <= idx_nx;
                ee_di <= frame_bit(cur_cmd, word_q, idx_nx);
              end
            end
          end
        end
        SQ_GAP: begin
          if (tick) begin
            if (gap_cnt == GAP_W'(GAP_TICKS - 1)) begin
              ee_cs <= 1'b1;
              state <= SQ_POLL;
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        SQ_POLL: begin
          if (tick && ee_do) begin
            ee_cs <= 1'b0;
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
  import uwe_pkg::*;
#(
  parameter int REG_AW    = 4,
  parameter int ADDR_BITS = 6,
  parameter int WORD_BITS = 16,
  parameter int CLK_DIV   = 4,
  parameter int GAP_TICKS = 2,
  parameter logic [REG_AW-1:0] CMD_OFS  = 4'hA,
  parameter logic [REG_AW-1:0] DATA_OFS = 4'hC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_AW-1:0]    host_addr,
  input  logic                 host_we,
  input  logic [WORD_BITS-1:0] host_wdata,
  output logic [WORD_BITS-1:0] host_rdata,
  output logic                 ee_cs,
  output logic                 ee_sk,
  output logic                 ee_di,
  input  logic                 ee_do
);

  localparam int CMD_W = OPC_BITS + ADDR_BITS;

  logic                 busy;
  logic                 run;
  logic                 tick;
  logic                 in_poll;
  logic                 start;
  logic                 dat_wr_ok;
  logic                 rd_done;
  logic [WORD_BITS-1:0] rd_word;
  logic [WORD_BITS-1:0] data_q;
  logic [CMD_W-1:0]     cur_cmd;

  uwe_hostregs #(
    .REG_AW   (REG_AW),
    .WORD_BITS(WORD_BITS),
    .CMD_W    (CMD_W),
    .CMD_OFS  (CMD_OFS),
    .DATA_OFS (DATA_OFS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_we   (host_we),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy      (busy),
    .cur_cmd   (cur_cmd),
    .rd_done   (rd_done),
    .rd_word   (rd_word),
    .start     (start),
    .dat_wr_ok (dat_wr_ok),
    .data_q    (data_q)
  );

  uwe_divider #(
    .CLK_DIV(CLK_DIV)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  uwe_seq #(
    .ADDR_BITS(ADDR_BITS),
    .WORD_BITS(WORD_BITS),
    .GAP_TICKS(GAP_TICKS)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .cmd_in (host_wdata[CMD_W-1:0]),
    .word_in(data_q),
    .tick   (tick),
    .ee_do  (ee_do),
    .busy   (busy),
    .run    (run),
    .in_poll(in_poll),
    .ee_cs  (ee_cs),
    .ee_sk  (ee_sk),
    .ee_di  (ee_di),
    .rd_done(rd_done),
    .rd_word(rd_word),
    .cur_cmd(cur_cmd)
  );

endmodule

// File: rtl/uwe_chk.sv
module uwe_chk #(
  parameter int WORD_BITS = 16,
  parameter int CMD_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 in_poll,
  input logic                 host_we,
  input logic                 dat_wr_ok,
  input logic                 rd_done,
  input logic                 ee_cs,
  input logic                 ee_sk,
  input logic                 ee_di,
  input logic                 ee_do,
  input logic [CMD_W-1:0]     cur_cmd,
  input logic [WORD_BITS-1:0] data_q
);

  // R4: nothing toggles on the serial side while idle
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk));

  // R4: serial clock only pulses inside a selected frame
  p_sk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  // R4: data-in is held steady while the serial clock is high
  p_di_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> $stable(ee_di));

  // R8: a command write during an operation leaves the running command alone
  p_cmd_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we) |=> $stable(cur_cmd));

  // R5: data register moves only on a host load or a completed read
  p_data_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(dat_wr_ok || rd_done));

  // R7: leaving the ready wait needs data-out high
  p_ready_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(in_poll)) |-> $past(ee_do));

endmodule

bind uwire_eeprom_ctrl uwe_chk #(
  .WORD_BITS(WORD_BITS),
  .CMD_W    (CMD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .in_poll  (in_poll),
  .host_we  (host_we),
  .dat_wr_ok(dat_wr_ok),
  .rd_done  (rd_done),
  .ee_cs    (ee_cs),
  .ee_sk    (ee_sk),
  .ee_di    (ee_di),
  .ee_do    (ee_do),
  .cur_cmd  (cur_cmd),
  .data_q   (data_q)
);

// File: tb/uwe_eeprom_model.sv
module uwe_eeprom_model #(
  parameter int ADDR_BITS = 6,
  parameter int WORD_BITS = 16,
  parameter int PROG_CYC  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);

  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int CMD_W = 2 + ADDR_BITS;
  localparam int HDR   = 1 + CMD_W;

  logic [WORD_BITS-1:0] mem [DEPTH];
  logic sk_q, cs_q, reading, wen, pend;
  logic [1:0] pend_op;
  logic [ADDR_BITS-1:0] pend_addr;
  logic [CMD_W-1:0] hdr_sr, h;
  logic [WORD_BITS-1:0] in_sr, out_sr;
  int nbits, prog;

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      mem[a] = 16'hA500 ^ {2'b00, 6'(a), 2'b11, 6'(a)};
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      sk_q <= 1'b0; cs_q <= 1'b0; reading <= 1'b0; wen <= 1'b0; pend <= 1'b0;
      nbits <= 0; prog <= 0; dout <= 1'b1; hdr_sr <= '0; in_sr <= '0; out_sr <= '0;
      pend_op <= 2'b00; pend_addr <= '0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
      if (prog > 0) prog <= prog - 1;
      if (!(cs && reading)) dout <= (prog == 0);
      if (!cs) begin
        nbits   <= 0;
        reading <= 1'b0;
      end
      if (cs_q && !cs && pend) begin
        pend <= 1'b0;
        if (wen) begin
          mem[pend_addr] <= (pend_op == 2'b11) ? '1 : in_sr;
          prog <= PROG_CYC;
          dout <= 1'b0;
        end
      end
      if (cs && sk && !sk_q) begin
        nbits <= nbits + 1;
        if (nbits > 0 && nbits < HDR - 1) begin
          hdr_sr <= {hdr_sr[CMD_W-2:0], di};
        end else if (nbits == HDR - 1) begin
          h = {hdr_sr[CMD_W-2:0], di};
          case (h[CMD_W-1 -: 2])
            2'b10: begin
              out_sr  <= mem[h[ADDR_BITS-1:0]];
              reading <= 1'b1;
              dout    <= 1'b0;
            end
            2'b01, 2'b11: begin
              pend      <= 1'b1;
              pend_op   <= h[CMD_W-1 -: 2];
              pend_addr <= h[ADDR_BITS-1:0];
            end
            default: begin
              if (h[ADDR_BITS-1 -: 2] == 2'b11) wen <= 1'b1;
              else if (h[ADDR_BITS-1 -: 2] == 2'b00) wen <= 1'b0;
            end
          endcase
        end else if (nbits >= HDR) begin
          if (reading) begin
            dout   <= out_sr[WORD_BITS-1];
            out_sr <= out_sr << 1;
          end else begin
            in_sr <= {in_sr[WORD_BITS-2:0], di};
          end
        end
      end
    end
  end

endmodule

// File: tb/uwire_eeprom_ctrl_bench.sv
module uwire_eeprom_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 3;
  localparam int PROG_CYC   = 200;
  localparam logic [3:0] CMD_OFS  = 4'hA;
  localparam logic [3:0] DATA_OFS = 4'hC;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_RDS = 2'd2;
  localparam int NVEC = 12;
  // {kind, address, value}
  localparam logic [23:0] VEC [NVEC] = '{
    {K_RDS, 6'h00, 16'h0000}, {K_RDS, 6'h3F, 16'h0000}, {K_RDS, 6'h15, 16'h0000},
    {K_WR,  6'h05, 16'h1234}, {K_RD,  6'h05, 16'h1234},
    {K_WR,  6'h3F, 16'h8001}, {K_RD,  6'h3F, 16'h8001},
    {K_WR,  6'h00, 16'hFFFE}, {K_RD,  6'h00, 16'hFFFE},
    {K_RDS, 6'h06, 16'h0000},
    {K_WR,  6'h05, 16'h0000}, {K_RD,  6'h05, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] host_addr = '0;
  logic host_we = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic ee_cs, ee_sk, ee_di, ee_do;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uwire_eeprom_ctrl #(
    .REG_AW(4), .ADDR_BITS(6), .WORD_BITS(16), .CLK_DIV(CLK_DIV), .GAP_TICKS(2),
    .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS)
  ) u_uwire_eeprom_ctrl (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  uwe_eeprom_model #(.ADDR_BITS(6), .WORD_BITS(16), .PROG_CYC(PROG_CYC)) u_model (
    .clk(clk), .rst_n(rst_n), .cs(ee_cs), .sk(ee_sk), .di(ee_di), .dout(ee_do)
  );

  // frame capture: data-in at each serial clock rise, and the cycle of the first two rises
  logic cap_clr = 1'b0;
  logic sk_prev;
  logic [31:0] cap_bits;
  int cap_n, cyc, t_first, t_second;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    sk_prev <= ee_sk;
    if (cap_clr) begin
      cap_n <= 0; cap_bits <= '0;
    end else if (ee_sk && !sk_prev) begin
      cap_bits <= {cap_bits[30:0], ee_di};
      cap_n <= cap_n + 1;
      if (cap_n == 0) t_first <= cyc;
      if (cap_n == 1) t_second <= cyc;
    end
  end
  initial cyc = 0;

  function automatic logic [15:0] seed_word(input logic [5:0] a);
    return 16'hA500 ^ {2'b00, a, 2'b11, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle(output int cycles);
    logic [15:0] v;
    cycles = 0;
    forever begin
      host_read(CMD_OFS, v);
      if (!v[15]) break;
      cycles++;
      if (cycles > 5000) begin
        check("R3 busy timeout", 32'(v), 32'(v & 16'h7FFF));
        break;
      end
    end
  endtask

  task automatic issue(input logic [7:0] c, output int cycles);
    host_write(CMD_OFS, {8'h00, c});
    wait_idle(cycles);
  endtask

  task automatic clear_cap();
    @(negedge clk); cap_clr = 1'b1;
    @(negedge clk); cap_clr = 1'b0;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] v);
    int c;
    issue(8'h30, c);
    issue({2'b11, a}, c);
    host_write(DATA_OFS, v);
    issue(8'h30, c);
    issue({2'b01, a}, c);
  endtask

  task automatic do_read(input logic [5:0] a, output logic [15:0] v);
    int c;
    issue({2'b10, a}, c);
    host_read(DATA_OFS, v);
  endtask

  initial begin
    logic [15:0] rv;
    int c;
    repeat (4) @(negedge clk);
    // R1: reset values on the serial pins and both registers
    check("R1 pins", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
    rst_n = 1'b1;
    host_read(CMD_OFS, rv);  check("R1 command reg", 32'(rv), 32'd0);
    host_read(DATA_OFS, rv); check("R1 data reg", 32'(rv), 32'd0);
    check("R1 pins after release", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);

    // R2: data register round trip and unmapped offsets
    host_write(DATA_OFS, 16'hBEEF);
    host_read(DATA_OFS, rv); check("R2 data readback", 32'(rv), 32'h0000BEEF);
    host_read(4'h0, rv);     check("R2 unmapped 0x0", 32'(rv), 32'd0);
    host_read(4'hB, rv);     check("R2 unmapped 0xB", 32'(rv), 32'd0);

    // table of reads (R5) and full update sequences (R7)
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] k; logic [5:0] a; logic [15:0] val;
      {k, a, val} = VEC[v];
      if (k == K_WR) begin
        do_write(a, val);
      end else begin
        do_read(a, rv);
        check(k == K_RD ? "R7 written word" : "R5 stored word", 32'(rv),
              32'(k == K_RD ? val : seed_word(a)));
      end
    end

    // R3 and R4 and R5: busy flag, frame bits, clock period, read data
    clear_cap();
    host_write(CMD_OFS, 16'h00AA);
    host_read(CMD_OFS, rv); check("R3 busy with command", 32'(rv), 32'h000080AA);
    wait_idle(c);
    host_read(CMD_OFS, rv); check("R3 idle with command", 32'(rv), 32'h000000AA);
    check("R5 serial clocks in read", 32'(cap_n), 32'd25);
    check("R4 read frame header", 32'(cap_bits[24:16]), 32'h1AA);
    check("R4 read data phase idle di", 32'(cap_bits[15:0]), 32'd0);
    check("R4 serial clock period", 32'(t_second - t_first), 32'(2 * CLK_DIV));
    host_read(DATA_OFS, rv); check("R5 read 0x2A", 32'(rv), 32'(seed_word(6'h2A)));

    // R6: unlock frame only
    clear_cap();
    issue(8'h30, c);
    check("R6 unlock serial clocks", 32'(cap_n), 32'd9);
    check("R6 unlock frame bits", 32'(cap_bits[8:0]), 32'h130);

    // R7: write frame carries data MSB first, then waits for ready
    host_write(DATA_OFS, 16'hC3A5);
    clear_cap();
    issue(8'h51, c);
    check("R7 write serial clocks", 32'(cap_n), 32'd25);
    check("R7 write frame bits", cap_bits & 32'h01FFFFFF, {7'd0, 9'b1_01_010001, 16'hC3A5});
    check("R7 write waits for program", 32'(c > PROG_CYC), 32'd1);
    do_read(6'h11, rv); check("R7 write stored", 32'(rv), 32'h0000C3A5);

    // R7: enabled erase holds busy through the program cycle
    issue(8'h30, c);
    issue(8'hE0, c);
    check("R7 erase waits for program", 32'(c > PROG_CYC), 32'd1);
    do_read(6'h20, rv); check("R7 erase result", 32'(rv), 32'h0000FFFF);

    // R8: register writes during an operation are dropped
    issue(8'h30, c);
    host_write(DATA_OFS, 16'h1111);
    host_write(CMD_OFS, 16'h00D2);
    host_write(DATA_OFS, 16'h5555);
    host_write(CMD_OFS, 16'h0081);
    wait_idle(c);
    host_read(DATA_OFS, rv); check("R8 data kept while busy", 32'(rv), 32'h00001111);
    host_read(CMD_OFS, rv);  check("R8 command kept while busy", 32'(rv), 32'h000000D2);
    do_read(6'h12, rv); check("R8 running erase completed", 32'(rv), 32'h0000FFFF);

    // R9: locked device ignores erase and write, busy ends without program wait
    issue(8'h00, c);
    issue(8'hC7, c);
    check("R9 locked erase short busy", 32'(c < PROG_CYC), 32'd1);
    do_read(6'h07, rv); check("R9 locked erase no effect", 32'(rv), 32'(seed_word(6'h07)));
    host_write(DATA_OFS, 16'h4321);
    issue(8'h47, c);
    do_read(6'h07, rv); check("R9 locked write no effect", 32'(rv), 32'(seed_word(6'h07)));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R3: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule